// File: doc/BRIEF.md
# Four-Level Translation Table Walker

This block translates one 64-bit input address at a time by walking a four-level, 64-bit-descriptor translation table in memory. A request carries the input address and the access type (read or write). The configuration inputs describe two table regions, a low one and a high one. Each region has a size field, a granule (log2 value 12, 14 or 16), a table base register and a disable flag. Two top-byte-ignore flags are shared by both regions. The walker picks a region and works out the start level and the first table base from that region's settings. It then reads 8-byte descriptors one at a time over a request/response memory port.

Each result is a single-cycle `done` pulse. The pulse carries either a translated output address with its read/write permissions, or a fault code. For faults that come from a descriptor, the fault address is the address of that descriptor. Only one walk is in flight at a time. A new request is taken only while the walker is idle.

Top module: `ptw_walker`

## Requirements
- R1: Region select: the low region is used when its size field is nonzero and the input address bits above the region (the top `size` bits) are all zero. Otherwise the high region is used when its size field is nonzero and those bits are all one. Otherwise a region whose size field is zero is used (low first, then high). If no region qualifies, the result is a translation fault (`fault_kind` = 1) with `fault_addr` = 0 and no memory read.
- R2: Input address bit 55 picks the applicable top-byte-ignore flag (`tbi_hi` when bit 55 is 1, `tbi_lo` when it is 0). When that flag is set, bits 63:56 are left out of the R1 checks.
- R3: stride = granule − 3, input size = 64 − size field, start level = 4 − (input size − 4) / stride with integer division truncating toward zero. The first table base is bits 47:0 of the region base with the low (input size − stride·(4 − start level)) bits cleared. Each descriptor is read at table base + 8·index. At each level the index is the stride-bit field of the input address (taken below the input size) starting at bit granule + (3 − level)·stride.
- R4: A granule other than 12, 14 or 16, a selected region with its disable flag set, or a start level outside 0..3 gives a translation fault with `fault_addr` = 0 and no memory read.
- R5: A descriptor read answered with `mem_rsp_err` = 1 gives an external-abort fault (`fault_kind` = 3) whose `fault_addr` is that descriptor's address.
- R6: A descriptor with bit 0 clear (invalid), with bit 1 clear at level 3, or with bit 1 clear at level 0 (reserved) gives a translation fault whose `fault_addr` is that descriptor's address.
- R7: A descriptor with bits 1:0 = 11 at levels 0–2 is a table descriptor. The next table base is its bits 47:0 with the low granule bits cleared, and the walk continues one level down.
- R8: A block descriptor (bits 1:0 = 01 at level 1 or 2) or a page descriptor (bits 1:0 = 11 at level 3) ends the walk. `out_addr` = descriptor bits 47:0 with the low L bits cleared, plus the input address's low L bits, where L = granule + (3 − level)·stride.
- R9: For a write, descriptor bit 7 set on the leaf, or bit 62 set on any table descriptor passed through, gives a permission fault (`fault_kind` = 2). Its `fault_addr` is that descriptor's address. Reads are never refused by these bits.
- R10: On success `fault_kind` = 0 and `out_perm` = {write allowed, read allowed} = {~bit 7 of the leaf, 1}. On any fault `out_perm` = 00.
- R11: `req_ready` is high only while idle. `mem_req_valid` is a one-cycle pulse, and no new one is issued before the response to the previous one. `done` is a one-cycle pulse per accepted request.
- R12: After reset the walker is idle: `req_ready` = 1, `done` = 0, `mem_req_valid` = 0, `fault_kind` = 0, `out_perm` = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_addr | input | 64 | Input address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| r0_size | input | 6 | Low region size field |
| r0_gran | input | 5 | Low region granule, log2 |
| r0_base | input | 64 | Low region table base register |
| r0_off | input | 1 | Low region disabled |
| r1_size | input | 6 | High region size field |
| r1_gran | input | 5 | High region granule, log2 |
| r1_base | input | 64 | High region table base register |
| r1_off | input | 1 | High region disabled |
| tbi_lo | input | 1 | Top-byte-ignore when address bit 55 is 0 |
| tbi_hi | input | 1 | Top-byte-ignore when address bit 55 is 1 |
| mem_req_valid | output | 1 | Descriptor read request pulse |
| mem_req_addr | output | 64 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor read response |
| mem_rsp_data | input | 64 | Descriptor value |
| mem_rsp_err | input | 1 | Descriptor read failed |
| done | output | 1 | Result valid pulse |
| fault_kind | output | 2 | 0 none, 1 translation, 2 permission, 3 external abort |
| fault_addr | output | 64 | Faulting descriptor address, 0 for configuration faults |
| out_addr | output | 64 | Translated address |
| out_perm | output | 2 | {write, read} permission |

## Verification
The assertions watch the handshake on every cycle. They check that `done` and `mem_req_valid` are single-cycle pulses, that `req_ready` drops once a request is taken, and that faults always return no permission while successes always grant read. The bench scenarios are what show region choice under both top-byte-ignore flags, the start level and first base for each granule, and the index arithmetic. They also cover descriptor decoding at each level, blocks against pages, and which descriptor a fault reports. These are compared against a bench-side walk over a memory whose descriptors are derived from their own address, with hand-built tables for the directed cases.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int PA_W = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_addr,
  input  logic        req_write,
  input  logic [5:0]  r0_size,
  input  logic [4:0]  r0_gran,
  input  logic [63:0] r0_base,
  input  logic        r0_off,
  input  logic [5:0]  r1_size,
  input  logic [4:0]  r1_gran,
  input  logic [63:0] r1_base,
  input  logic        r1_off,
  input  logic        tbi_lo,
  input  logic        tbi_hi,
  output logic        mem_req_valid,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        done,
  output logic [1:0]  fault_kind,
  output logic [63:0] fault_addr,
  output logic [63:0] out_addr,
  output logic [1:0]  out_perm
);
  localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;
  localparam logic [1:0] F_NONE  = 2'd0;
  localparam logic [1:0] F_XLAT  = 2'd1;
  localparam logic [1:0] F_PERM  = 2'd2;
  localparam logic [1:0] F_ABORT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_RESP} st_t;
  st_t state;

  function automatic logic [63:0] top_mask(input logic [5:0] sz, input logic tb);
    logic [63:0] m;
    m = ~({64{1'b1}} >> sz);
    if (tb) m = m & 64'h00FF_FFFF_FFFF_FFFF;
    return m;
  endfunction

  logic        tbi_on, hit0, hit1, pick1, sel_ok, gran_ok, cfg_ok;
  logic [63:0] m0, m1, s_base, base0;
  logic [5:0]  s_size;
  logic [4:0]  s_gran, s_stride;
  logic        s_off;
  logic [6:0]  s_insz;
  int          s_lvl, s_tbits;

  assign tbi_on = req_addr[55] ? tbi_hi : tbi_lo;
  assign m0 = top_mask(r0_size, tbi_on);
  assign m1 = top_mask(r1_size, tbi_on);
  assign hit0 = (r0_size != 6'd0) && ((req_addr & m0) == 64'd0);
  assign hit1 = (r1_size != 6'd0) && ((req_addr & m1) == m1);
  assign pick1 = !hit0 && (hit1 || (r0_size != 6'd0 && r1_size == 6'd0));
  assign sel_ok = hit0 || hit1 || (r0_size == 6'd0) || (r1_size == 6'd0);

  assign s_size = pick1 ? r1_size : r0_size;
  assign s_gran = pick1 ? r1_gran : r0_gran;
  assign s_base = pick1 ? r1_base : r0_base;
  assign s_off  = pick1 ? r1_off  : r0_off;

  assign gran_ok  = (s_gran == 5'd12) || (s_gran == 5'd14) || (s_gran == 5'd16);
  assign s_stride = gran_ok ? (s_gran - 5'd3) : 5'd9;
  assign s_insz   = 7'd64 - {1'b0, s_size};

  always_comb begin
    s_lvl   = 4 - ((int'(s_insz) - 4) / int'(s_stride));
    s_tbits = int'(s_insz) - int'(s_stride) * (4 - s_lvl);
  end

  assign cfg_ok = sel_ok && !s_off && gran_ok && (s_lvl >= 0) && (s_lvl <= 3);
  assign base0  = s_base & PA_MASK & ~((64'd1 << s_tbits[5:0]) - 64'd1);

  logic [63:0] a_addr, base_r;
  logic        a_wr;
  logic [4:0]  g_r;
  logic [6:0]  insz_r;
  logic [1:0]  lvl_r;

  logic [4:0]  stride_r;
  logic [6:0]  sh;
  logic [63:0] in_mask, idx, desc_addr, leaf_mask, gmask;

  assign stride_r  = g_r - 5'd3;
  assign sh        = 7'(g_r) + 7'(2'd3 - lvl_r) * 7'(stride_r);
  assign in_mask   = (insz_r >= 7'd64) ? {64{1'b1}} : ((64'd1 << insz_r) - 64'd1);
  assign idx       = ((a_addr & in_mask) >> sh) & ((64'd1 << stride_r) - 64'd1);
  assign desc_addr = base_r + (idx << 3);
  assign leaf_mask = (64'd1 << sh) - 64'd1;
  assign gmask     = (64'd1 << g_r) - 64'd1;

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr  = desc_addr;
  assign done          = (state == S_RESP);

  logic is_table, is_leaf, is_bad;
  assign is_bad   = !mem_rsp_data[0] || (!mem_rsp_data[1] && (lvl_r == 2'd3 || lvl_r == 2'd0));
  assign is_table = !is_bad && mem_rsp_data[1] && (lvl_r != 2'd3);
  assign is_leaf  = !is_bad && !is_table;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      a_addr     <= '0;
      a_wr       <= 1'b0;
      g_r        <= 5'd12;
      insz_r     <= '0;
      lvl_r      <= '0;
      base_r     <= '0;
      fault_kind <= F_NONE;
      fault_addr <= '0;
      out_addr   <= '0;
      out_perm   <= 2'b00;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          a_addr <= req_addr;
          a_wr   <= req_write;
          g_r    <= gran_ok ? s_gran : 5'd12;
          insz_r <= s_insz;
          lvl_r  <= s_lvl[1:0];
          base_r <= base0;
          if (cfg_ok) begin
            state <= S_REQ;
          end else begin
            fault_kind <= F_XLAT;
            fault_addr <= '0;
            out_addr   <= '0;
            out_perm   <= 2'b00;
            state      <= S_RESP;
          end
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err || is_bad ||
              (a_wr && is_table && mem_rsp_data[62]) ||
              (a_wr && is_leaf && mem_rsp_data[7])) begin
            fault_kind <= mem_rsp_err ? F_ABORT : (is_bad ? F_XLAT : F_PERM);
            fault_addr <= desc_addr;
            out_addr   <= '0;
            out_perm   <= 2'b00;
            state      <= S_RESP;
          end else if (is_table) begin
            base_r <= mem_rsp_data & PA_MASK & ~gmask;
            lvl_r  <= lvl_r + 2'd1;
            state  <= S_REQ;
          end else begin
            fault_kind <= F_NONE;
            fault_addr <= '0;
            out_addr   <= (mem_rsp_data & PA_MASK & ~leaf_mask) + (a_addr & leaf_mask);
            out_perm   <= {~mem_rsp_data[7], 1'b1};
            state      <= S_RESP;
          end
        end
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  req_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R11
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  fault_noperm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind != F_NONE) |-> (out_perm == 2'b00));
  // R10
  ok_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind == F_NONE) |-> out_perm[0]);
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write;
  logic [63:0] req_addr;
  logic [5:0]  r0_size, r1_size;
  logic [4:0]  r0_gran, r1_gran;
  logic [63:0] r0_base, r1_base;
  logic        r0_off, r1_off, tbi_lo, tbi_hi;
  logic        mem_req_valid, mem_rsp_valid, mem_rsp_err, done;
  logic [63:0] mem_req_addr, mem_rsp_data, fault_addr, out_addr;
  logic [1:0]  fault_kind, out_perm;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write),
    .r0_size(r0_size), .r0_gran(r0_gran), .r0_base(r0_base), .r0_off(r0_off),
    .r1_size(r1_size), .r1_gran(r1_gran), .r1_base(r1_base), .r1_off(r1_off),
    .tbi_lo(tbi_lo), .tbi_hi(tbi_hi),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .done(done), .fault_kind(fault_kind), .fault_addr(fault_addr),
    .out_addr(out_addr), .out_perm(out_perm)
  );

  int n_chk = 0, n_bad = 0, reads = 0;
  logic [63:0] ovr [logic [63:0]];
  bit          errs [logic [63:0]];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] mix(input logic [63:0] a);
    logic [63:0] h;
    h = a ^ (a >> 31);
    h = h * 64'hBF58_476D_1CE4_E5B9;
    h = h ^ (h >> 27);
    return h;
  endfunction

  function automatic void fetch(input logic [63:0] a, output logic [63:0] d, output bit e);
    logic [63:0] h;
    if (ovr.exists(a)) begin d = ovr[a]; e = errs.exists(a); return; end
    if (errs.exists(a)) begin d = '0; e = 1'b1; return; end
    h = mix(a);
    e = (h[3:0] == 4'd0);
    d = '0;
    d[0] = (h[6:4] != 3'd0);
    d[1] = (h[6:4] > 3'd1);
    d[7] = h[8];
    d[62] = h[9] & h[10];
    d[47:12] = h[59:24];
  endfunction

  // memory model: one outstanding read, random latency
  logic [63:0] pend, md;
  bit busy = 1'b0, me;
  int lat = 0;
  initial begin
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (busy) begin
        if (lat == 0) begin
          fetch(pend, md, me);
          mem_rsp_valid = 1'b1; mem_rsp_data = md; mem_rsp_err = me; busy = 1'b0;
        end else lat--;
      end
      if (mem_req_valid) begin
        if (busy) chk(1'b0, "R11 overlapping descriptor read", 64'd1, 64'd0);
        reads++;
        pend = mem_req_addr; busy = 1'b1; lat = $urandom_range(0, 3);
      end
    end
  end

  function automatic void ref_walk(input logic [63:0] a, input bit wr,
      output logic [1:0] k, output logic [63:0] oa, output logic [1:0] pm,
      output logic [63:0] fa, output int nr);
    bit tb, off, e;
    logic [63:0] m0, m1, base, idx, da, d;
    int sel, sz, g, insz, st, lvl, sh, tbits;
    k = 2'd1; oa = '0; pm = 2'b00; fa = '0; nr = 0;
    tb = a[55] ? tbi_hi : tbi_lo;
    m0 = '0; m1 = '0;
    for (int i = 64 - int'(r0_size); i < 64; i++) m0[i] = 1'b1;
    for (int i = 64 - int'(r1_size); i < 64; i++) m1[i] = 1'b1;
    if (tb) begin m0[63:56] = 8'd0; m1[63:56] = 8'd0; end
    sel = -1;
    if (r0_size != 0 && (a & m0) == 0) sel = 0;
    else if (r1_size != 0 && (a & m1) == m1) sel = 1;
    else if (r0_size == 0) sel = 0;
    else if (r1_size == 0) sel = 1;
    if (sel < 0) return;
    sz = (sel == 1) ? int'(r1_size) : int'(r0_size);
    g = (sel == 1) ? int'(r1_gran) : int'(r0_gran);
    off = (sel == 1) ? r1_off : r0_off;
    base = (sel == 1) ? r1_base : r0_base;
    if (off || !(g == 12 || g == 14 || g == 16)) return;
    insz = 64 - sz; st = g - 3;
    lvl = 4 - (insz - 4) / st;
    if (lvl < 0 || lvl > 3) return;
    tbits = insz - st * (4 - lvl);
    base = {16'd0, base[47:0]};
    for (int i = 0; i < tbits; i++) base[i] = 1'b0;
    while (1) begin
      sh = g + (3 - lvl) * st;
      idx = '0;
      for (int i = 0; i < st; i++) if (sh + i < insz) idx[i] = a[sh + i];
      da = base + idx * 8;
      fetch(da, d, e);
      nr++;
      fa = da;
      if (e) begin k = 2'd3; return; end
      if (!d[0]) return;
      if (lvl == 3 && !d[1]) return;
      if (lvl < 3 && d[1]) begin
        if (wr && d[62]) begin k = 2'd2; return; end
        base = {16'd0, d[47:0]};
        for (int i = 0; i < g; i++) base[i] = 1'b0;
        lvl++;
        continue;
      end
      if (lvl == 0) return;
      if (wr && d[7]) begin k = 2'd2; return; end
      k = 2'd0; fa = '0;
      oa = {16'd0, d[47:0]};
      for (int i = 0; i < sh; i++) oa[i] = a[i];
      pm = {~d[7], 1'b1};
      return;
    end
  endfunction

  logic [1:0]  gk, gp;
  logic [63:0] go, gf;
  int          gn;

  task automatic walk(input logic [63:0] a, input bit wr, input string tag);
    int t;
    @(negedge clk);
    reads = 0;
    req_addr = a; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R11 ready low while busy"}, 64'(req_ready), 64'd0);
    t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    if (!done) chk(1'b0, {tag, " watchdog"}, 64'd0, 64'd1);
    gk = fault_kind; gp = out_perm; go = out_addr; gf = fault_addr; gn = reads;
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, {tag, " R11 done pulse"}, 64'({done, req_ready}), 64'd1);
  endtask

  task automatic dwalk(input logic [63:0] a, input bit wr, input string tag,
      input logic [1:0] ek, input logic [63:0] eaddr, input logic [1:0] ep, input int en);
    walk(a, wr, tag);
    chk(gk == ek, {tag, " kind"}, 64'(gk), 64'(ek));
    chk(gp == ep, {tag, " R10 perm"}, 64'(gp), 64'(ep));
    if (ek == 2'd0) chk(go == eaddr, {tag, " out_addr"}, go, eaddr);
    else chk(gf == eaddr, {tag, " fault_addr"}, gf, eaddr);
    chk(gn == en, {tag, " reads"}, 64'(gn), 64'(en));
  endtask

  task automatic rwalk(input logic [63:0] a, input bit wr, input string tag);
    logic [1:0] ek, ep; logic [63:0] eo, ef; int en;
    ref_walk(a, wr, ek, eo, ep, ef, en);
    walk(a, wr, tag);
    chk(gk == ek, {tag, " kind"}, 64'(gk), 64'(ek));
    chk(gp == ep, {tag, " R10 perm"}, 64'(gp), 64'(ep));
    chk(go == eo, {tag, " R8 out_addr"}, go, eo);
    chk(gf == ef, {tag, " fault_addr"}, gf, ef);
    chk(gn == en, {tag, " R3 reads"}, 64'(gn), 64'(en));
  endtask

  function automatic logic [4:0] rgran();
    if ($urandom_range(0, 15) == 0) return 5'd13;
    case ($urandom_range(0, 2))
      0: return 5'd12;
      1: return 5'd14;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [5:0] rsize();
    case ($urandom_range(0, 19))
      0: return 6'd0;
      1: return 6'd62;
      default: return 6'(64 - $urandom_range(25, 48));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "global watchdog", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] a;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    r0_size = 6'd25; r0_gran = 5'd12; r0_base = 64'hFFFF_0000_0010_0000; r0_off = 1'b0;
    r1_size = 6'd25; r1_gran = 5'd12; r1_base = 64'h0000_0000_0060_0000; r1_off = 1'b0;
    tbi_lo = 1'b0; tbi_hi = 1'b0;
    repeat (3) @(negedge clk);
    // R12
    chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R12 idle after reset",
        64'({req_ready, done, mem_req_valid}), 64'd4);
    chk(fault_kind == 2'd0 && out_perm == 2'b00, "R12 result regs", 64'({fault_kind, out_perm}), 64'd0);
    rst_n = 1'b1;

    ovr[64'h10_0010] = 64'h0000_0000_0020_0F03;
    ovr[64'h20_0018] = 64'h0000_0000_0030_0003;
    ovr[64'h30_0020] = 64'h0000_0000_8888_8003;
    ovr[64'h20_0028] = 64'h0000_0000_4000_1001;
    ovr[64'h10_0008] = 64'h0000_0080_0000_0001;
    ovr[64'h10_0018] = 64'h4000_0000_0020_0003;
    ovr[64'h20_0030] = 64'h0;
    ovr[64'h30_0038] = 64'h0000_0000_9999_9001;
    ovr[64'h60_0000] = 64'h0000_0077_4000_0001;
    ovr[64'h50_0008] = 64'h0000_0000_7000_0001;
    errs[64'h10_0020] = 1'b1;

    // R3 R7 R8: three-level page walk, base bits above 47 dropped, table low bits ignored
    dwalk(64'h8060_4ABC, 1'b0, "R3 R7 R8 page read", 2'd0, 64'h8888_8ABC, 2'b11, 3);
    dwalk(64'h8060_4ABC, 1'b1, "R10 page write ok", 2'd0, 64'h8888_8ABC, 2'b11, 3);
    dwalk(64'h80A1_2345, 1'b0, "R8 level-2 block", 2'd0, 64'h4001_2345, 2'b11, 2);
    dwalk(64'h5234_5678, 1'b0, "R8 level-1 block", 2'd0, 64'h80_1234_5678, 2'b11, 1);
    ovr[64'h30_0020] = 64'h0000_0000_8888_8083;
    dwalk(64'h8060_4ABC, 1'b1, "R9 leaf write denied", 2'd2, 64'h30_0020, 2'b00, 3);
    dwalk(64'h8060_4ABC, 1'b0, "R10 read-only leaf", 2'd0, 64'h8888_8ABC, 2'b01, 3);
    dwalk(64'hC060_4ABC, 1'b1, "R9 table write denied", 2'd2, 64'h10_0018, 2'b00, 1);
    dwalk(64'hC060_4ABC, 1'b0, "R9 table read passes", 2'd0, 64'h8888_8ABC, 2'b01, 3);
    dwalk(64'h80C0_0000, 1'b0, "R6 invalid descriptor", 2'd1, 64'h20_0030, 2'b00, 2);
    dwalk(64'h8060_7000, 1'b0, "R6 reserved at level 3", 2'd1, 64'h30_0038, 2'b00, 3);
    dwalk(64'h1_0000_0000, 1'b0, "R5 external abort", 2'd3, 64'h10_0020, 2'b00, 1);
    dwalk(64'hFFFF_FF80_0000_1234, 1'b0, "R1 high region", 2'd0, 64'h77_4000_1234, 2'b11, 1);
    dwalk(64'h0100_0000_0000_0000, 1'b0, "R1 gap fault", 2'd1, 64'd0, 2'b00, 0);
    dwalk(64'h5A00_0000_8060_4ABC, 1'b0, "R2 tbi_lo clear", 2'd1, 64'd0, 2'b00, 0);
    tbi_lo = 1'b1;
    dwalk(64'h5A00_0000_8060_4ABC, 1'b0, "R2 tbi_lo set", 2'd0, 64'h8888_8ABC, 2'b01, 3);
    dwalk(64'h00FF_FF80_0000_1234, 1'b0, "R2 bit55 uses tbi_hi clear", 2'd1, 64'd0, 2'b00, 0);
    tbi_lo = 1'b0; tbi_hi = 1'b1;
    dwalk(64'h00FF_FF80_0000_1234, 1'b0, "R2 bit55 uses tbi_hi set", 2'd0, 64'h77_4000_1234, 2'b11, 1);
    tbi_hi = 1'b0;
    r0_off = 1'b1;
    dwalk(64'h8060_4ABC, 1'b0, "R4 disabled region", 2'd1, 64'd0, 2'b00, 0);
    r0_off = 1'b0; r0_gran = 5'd13;
    dwalk(64'h8060_4ABC, 1'b0, "R4 bad granule", 2'd1, 64'd0, 2'b00, 0);
    r0_gran = 5'd12; r0_size = 6'd16; r0_base = 64'h50_0000;
    dwalk(64'h80_0000_0000, 1'b0, "R6 block at level 0", 2'd1, 64'h50_0008, 2'b00, 1);
    r0_size = 6'd0;
    rwalk(64'h8060_4ABC, 1'b0, "R1 R4 size-zero fallback");

    for (int n = 0; n < 400; n++) begin
      r0_size = rsize(); r1_size = rsize();
      r0_gran = rgran(); r1_gran = rgran();
      r0_base = {$urandom, $urandom}; r1_base = {$urandom, $urandom};
      r0_off = ($urandom_range(0, 15) == 0); r1_off = ($urandom_range(0, 15) == 0);
      tbi_lo = $urandom_range(0, 1); tbi_hi = $urandom_range(0, 1);
      a = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: for (int i = 64 - int'(r0_size); i < 64; i++) a[i] = 1'b0;
        1: for (int i = 64 - int'(r1_size); i < 64; i++) a[i] = 1'b1;
        2: ;
        default: begin
          for (int i = 64 - int'(r0_size); i < 64; i++) a[i] = 1'b0;
          a[63:56] = 8'($urandom);
        end
      endcase
      rwalk(a, 1'($urandom_range(0, 1)), "R1 R2 R3 R5 R6 R7 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule